// File: doc/BRIEF.md
# Shift Register with Shift-Priority Parallel Load

This block is a four-bit storage register with two controls. A shift control moves the stored word one place toward bit 0 on each rising clock edge. The serial input fills the top bit, and the bit at position 0 leaves the register. A load control captures a four-bit parallel word. When both controls are low, the word stays as it is. When both controls are high, the shift wins and the parallel word is not used.

The controls are decoded into one of three named operations: `OP_HOLD`, `OP_LOAD` and `OP_SHIFT`. A per-bit datapath then applies the chosen operation. The transitions are fixed by the controls:
- shift high, whatever load is, selects `OP_SHIFT`.
- load high with shift low selects `OP_LOAD`.
- both controls low select `OP_HOLD`.

An asynchronous active-high reset clears the register to zero.

Top module: `shreg_prio`

## Requirements
- R1: While `rst` is 1, `par_out` is 4'b0000, independent of the clock and of every other input.
- R2: With `shift_en`=0 and `load_en`=0, `par_out` keeps its value across a rising clock edge.
- R3: With `load_en`=1 and `shift_en`=0, `par_out` equals the `par_in` value sampled at the rising edge.
- R4: With `shift_en`=1, a rising edge makes bit i of `par_out` equal to the previous bit i+1 for i = 0 to 2. Bit 3 takes `ser_in`.
- R5: With `shift_en`=1 and `load_en`=1, the shift of R4 is performed and `par_in` has no effect on `par_out`.
- R6: `ser_out` always shows bit 0 of the stored word. Right after a shift, it therefore shows the previous bit 1.
- R7: Starting from 4'b0110, six shifts with serial bits 1,0,1,1,1,0 give 1011, 0101, 1010, 1101, 1110, 0111 in turn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high clear |
| shift_en | input | 1 | Shift toward bit 0; overrides load |
| load_en | input | 1 | Parallel capture when shift is low |
| ser_in | input | 1 | Bit entering position 3 on a shift |
| par_in | input | 4 | Parallel data word |
| par_out | output | 4 | Stored word |
| ser_out | output | 1 | Current bit 0 of the stored word |

## Verification
On every clock, the assertions check the three operation results (hold, load and shift) against the sampled inputs. They also check the clear during reset and the bit that `ser_out` shows after a shift. Only the bench's scenarios show the following:
- that the priority case actually discards a differing parallel word;
- the exact six-step word sequence;
- that a reset asserted mid-operation clears the register at once, without waiting for a clock edge.

// File: rtl/shreg_prio_pkg.sv
package shreg_prio_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } shreg_op_e;
endpackage

// File: rtl/shreg_prio_ctrl.sv
module shreg_prio_ctrl
    import shreg_prio_pkg::*;
(
    input  logic      shift_en,
    input  logic      load_en,
    output shreg_op_e op
);
    // Shift has priority over load; load acts only when shift is low.
    always_comb begin
        if (shift_en)     op = OP_SHIFT;
        else if (load_en) op = OP_LOAD;
        else              op = OP_HOLD;
    end
endmodule

// File: rtl/shreg_prio_datapath.sv
module shreg_prio_datapath
    import shreg_prio_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  shreg_op_e    op,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic upper;
        if (i == W-1) begin : g_top
            assign upper = ser_in;
        end else begin : g_mid
            assign upper = q[i+1];
        end

        always_comb begin
            unique case (op)
                OP_SHIFT: nxt[i] = upper;
                OP_LOAD:  nxt[i] = par_in[i];
                OP_HOLD:  nxt[i] = q[i];
                default:  nxt[i] = q[i];
            endcase
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/shreg_prio.sv
module shreg_prio
    import shreg_prio_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         load_en,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic [W-1:0] par_out,
    output logic         ser_out
);
    shreg_op_e    op;
    logic [W-1:0] q;

    shreg_prio_ctrl u_ctrl (
        .shift_en (shift_en),
        .load_en  (load_en),
        .op       (op)
    );

    shreg_prio_datapath #(.W(W)) u_dp (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .ser_in (ser_in),
        .par_in (par_in),
        .q      (q)
    );

    assign par_out = q;
    assign ser_out = q[0];
endmodule

// File: rtl/shreg_prio_chk.sv
module shreg_prio_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         shift_en,
    input logic         load_en,
    input logic         ser_in,
    input logic [W-1:0] par_in,
    input logic [W-1:0] par_out,
    input logic         ser_out
);
    a_r1_reset_clear: assert property (@(posedge clk) rst |-> par_out == '0);

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !load_en) |=> $stable(par_out));

    a_r3_load: assert property (@(posedge clk) disable iff (rst)
        (load_en && !shift_en) |=> par_out == $past(par_in));

    // R4 and R5: shift regardless of load
    a_r4_shift: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> par_out == {$past(ser_in), $past(par_out[W-1:1])});

    a_r6_ser_out: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> ser_out == $past(par_out[1]));
endmodule

bind shreg_prio shreg_prio_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .load_en  (load_en),
    .ser_in   (ser_in),
    .par_in   (par_in),
    .par_out  (par_out),
    .ser_out  (ser_out)
);

// File: tb/shreg_prio_test.sv
`timescale 1ns/1ps
module shreg_prio_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       shift_en = 1'b0, load_en = 1'b0, ser_in = 1'b0;
    logic [3:0] par_in = 4'h0;
    logic [3:0] par_out;
    logic       ser_out;

    int checks = 0, errors = 0;
    bit model[$];   // model[0] is bit 0

    always #2.5 clk = ~clk;

    shreg_prio uut (
        .clk(clk), .rst(rst), .shift_en(shift_en), .load_en(load_en),
        .ser_in(ser_in), .par_in(par_in), .par_out(par_out), .ser_out(ser_out)
    );

    function automatic logic [3:0] mword();
        logic [3:0] v;
        for (int i = 0; i < 4; i++) v[i] = model[i];
        return v;
    endfunction

    task automatic check(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic model_clear();
        model.delete();
        for (int i = 0; i < 4; i++) model.push_back(1'b0);
    endtask

    // one clocked step; inputs driven at negedge, compared at next negedge
    task automatic step(string req, logic s, logic l, logic si, logic [3:0] pi);
        shift_en = s; load_en = l; ser_in = si; par_in = pi;
        check({req, " ser_out"}, {3'b0, ser_out}, {3'b0, model[0]});
        @(posedge clk);
        if (s) begin
            void'(model.pop_front());
            model.push_back(si);
        end else if (l) begin
            model.delete();
            for (int i = 0; i < 4; i++) model.push_back(pi[i]);
        end
        @(negedge clk);
        check(req, par_out, mword());
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_clear();
        repeat (2) @(negedge clk);
        check("R1 reset", par_out, 4'b0000);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", par_out, 4'b0000);

        // R3 load, R2 hold
        step("R3 load 1001", 1'b0, 1'b1, 1'b0, 4'b1001);
        step("R2 hold", 1'b0, 1'b0, 1'b1, 4'b0110);
        step("R2 hold again", 1'b0, 1'b0, 1'b0, 4'b1111);
        step("R3 load 0110", 1'b0, 1'b1, 1'b1, 4'b0110);

        // R7 sequence, with R4 and R6 checked along the way
        begin
            logic [3:0] exp_seq [6] = '{4'b1011, 4'b0101, 4'b1010,
                                        4'b1101, 4'b1110, 4'b0111};
            logic bits [6] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
            for (int k = 0; k < 6; k++) begin
                step("R4 shift", 1'b1, 1'b0, bits[k], 4'b0000);
                check("R7 sequence", par_out, exp_seq[k]);
                check("R6 ser_out", {3'b0, ser_out}, {3'b0, exp_seq[k][0]});
            end
        end

        // R5 both high: shift wins, differing par_in ignored
        step("R3 load 0000", 1'b0, 1'b1, 1'b0, 4'b0000);
        step("R5 both high", 1'b1, 1'b1, 1'b1, 4'b0111);
        check("R5 priority", par_out, 4'b1000);
        step("R5 both high 2", 1'b1, 1'b1, 1'b0, 4'b1111);
        check("R5 priority 2", par_out, 4'b0100);

        // mixed patterns
        for (int k = 0; k < 40; k++) begin
            step("R2/R3/R4 mix", k[0], k[1] ^ k[3], k[2], 4'(k * 7));
        end

        // R1 reset on the fly, asynchronous
        step("R3 load 1111", 1'b0, 1'b1, 1'b0, 4'b1111);
        #1 rst = 1'b1;
        #0.5;
        check("R1 async clear", par_out, 4'b0000);
        model_clear();
        @(negedge clk);
        rst = 1'b0;
        step("R3 load after reset", 1'b0, 1'b1, 1'b0, 4'b1010);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule